// File: doc/BRIEF.md
# Write-Unlock Sequence Guard

This block sits between the byte-write port of a parallel nonvolatile memory and its page latch and write timer. It watches each byte write strobe, together with its address and data, for two fixed command patterns. A three-byte pattern arms protection. The same pattern, issued while protection is on, also opens the current load window for real data. A six-byte pattern disarms protection. Command bytes are consumed: they never reach the page latch. Any byte that breaks a pattern is handled as an ordinary write attempt.

The protect flag survives everything except a power-on reset and the disarm pattern. A change of protection is held as pending. It takes effect when the write timer reports the end of the write cycle that follows the load window. While protection is on, a byte that is not covered by the arm pattern is refused. The block then asks the write timer for a dummy busy period, so that reads poll as they would during a real write. The load window closes after `LOAD_WINDOW` clock cycles with no strobe, and the next strobe opens a new one.

Top module: `wp_unlock_guard`

## Requirements
- R1: Power-on reset (`rstN` low) clears the protect flag. After reset, `wrPermit` and `dummyStart` stay low while `wrStb` is low.
- R2: While unprotected, a strobe that is not a command byte raises `wrPermit` in the same cycle as `wrStb`.
- R3: A byte that starts, continues or completes a command pattern never raises `wrPermit`. The pattern bytes are data AA at address 5555, then 55 at 2AAA, and then either A0 at 5555 (arm), or 80 at 5555 followed by AA at 5555, 55 at 2AAA and 20 at 5555 (disarm). All values are hex.
- R4: After the arm pattern, `protectOn` rises on the clock edge that samples `cycleDone` high, at the first `cycleDone` after the load window has closed.
- R5: `protectOn` changes only on an edge where `cycleDone` is high. A `cycleDone` that arrives while the window holding the pattern is still open changes nothing.
- R6: While protected and not unlocked, a data byte gets no `wrPermit`. The first such byte in a load window pulses `dummyStart` in its own cycle, and later refused bytes in the same window do not.
- R7: After the arm pattern, every byte for the rest of that load window is permitted, including bytes at command addresses with command values.
- R8: The load window closes when `LOAD_WINDOW` cycles pass with no strobe. A partial pattern is then discarded, so the next byte is matched from the start.
- R9: The disarm pattern, followed by data in the same window, permits that data. `protectOn` falls at the first `cycleDone` after the window closes.
- R10: A byte that breaks a pattern returns the matcher to idle and is handled as an ordinary write, unless that byte is itself AA at 5555, in which case it begins a new pattern.
- R11: When a window with a pending arm or disarm closes with no data byte loaded, `dummyStart` pulses once, so that the timer still runs the cycle that commits the change.
- R12: Protection persists across refused writes, window closures and unlocked loads; only the disarm pattern or reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| wrStb | input | 1 | One-cycle byte write strobe |
| wrAddr | input | 15 | Byte address of the strobe |
| wrData | input | 8 | Byte data of the strobe |
| cycleDone | input | 1 | Pulse from the write timer at the end of a write cycle |
| wrPermit | output | 1 | Store this byte in the page latch (same cycle as strobe) |
| protectOn | output | 1 | Protect flag |
| dummyStart | output | 1 | Pulse asking the timer to start a busy period with no data |

## Verification
The assertions assume that `cycleDone` comes only from a write cycle the timer started after a load window closed. They also assume that `wrAddr` and `wrData` are valid whenever `wrStb` is high. The stimulus raises `cycleDone` only on strobe-free cycles, except once on purpose to show that an early pulse is ignored. Strobes within a window are spaced well under `LOAD_WINDOW` cycles apart, and windows are closed with gaps well beyond it, so no strobe lands on the exact expiry cycle.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

  // Which of the fixed pattern bytes the current strobe carries
  typedef struct packed {
    logic lead;     // AA at first command address
    logic second;   // 55 at second command address
    logic arm;      // A0 at first command address
    logic extend;   // 80 at first command address
    logic disarm;   // 20 at first command address
  } patHit_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic openWin;
    logic setProt;
    logic clrProt;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GOT1,
    ST_GOT2,
    ST_DIS3,
    ST_DIS4,
    ST_DIS5
  } step_t;

endpackage

// File: rtl/wp_guard_datapath.sv
module wp_guard_datapath
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int LOAD_WINDOW = 32,
  parameter logic [ADDR_W-1:0] ADDR_A = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] CODE_LEAD = 8'hAA,
  parameter logic [DATA_W-1:0] CODE_SECOND = 8'h55,
  parameter logic [DATA_W-1:0] CODE_ARM = 8'hA0,
  parameter logic [DATA_W-1:0] CODE_EXTEND = 8'h80,
  parameter logic [DATA_W-1:0] CODE_DISARM = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  dpCtrl_t           ctrl,
  output patHit_t           hits,
  output logic              winExpire,
  output logic              protectOn
);

  localparam int NPAT = 5;
  localparam int WIN_W = $clog2(LOAD_WINDOW + 1);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(LOAD_WINDOW);
  localparam logic [ADDR_W-1:0] PAT_ADDR [NPAT] = '{ADDR_A, ADDR_B, ADDR_A, ADDR_A, ADDR_A};
  localparam logic [DATA_W-1:0] PAT_DATA [NPAT] =
    '{CODE_LEAD, CODE_SECOND, CODE_ARM, CODE_EXTEND, CODE_DISARM};

  logic [NPAT-1:0] hitVec;
  logic [WIN_W-1:0] winCnt;
  logic protQ;

  for (genvar i = 0; i < NPAT; i++) begin : g_pat
    assign hitVec[i] = (wrAddr == PAT_ADDR[i]) && (wrData == PAT_DATA[i]);
  end

  assign hits = '{lead: hitVec[0], second: hitVec[1], arm: hitVec[2],
                  extend: hitVec[3], disarm: hitVec[4]};

  // Load-window countdown, reloaded by every strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (ctrl.openWin) begin
      winCnt <= WIN_LOAD;
    end else if (winCnt != '0) begin
      winCnt <= winCnt - 1'b1;
    end
  end

  assign winExpire = (winCnt == WIN_W'(1)) && !ctrl.openWin;

  // Persistent protect flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protQ <= 1'b0;
    end else if (ctrl.setProt) begin
      protQ <= 1'b1;
    end else if (ctrl.clrProt) begin
      protQ <= 1'b0;
    end
  end

  assign protectOn = protQ;

  AST_WINDOW_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.openWin |=> winCnt == WIN_LOAD) else $error("window not reloaded"); // R8

  AST_WINDOW_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    winExpire |=> winCnt == '0) else $error("window not closed"); // R8

endmodule

// File: rtl/wp_guard_control.sv
module wp_guard_control
  import wp_guard_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrStb,
  input  patHit_t hits,
  input  logic    winExpire,
  input  logic    protectOn,
  input  logic    cycleDone,
  output dpCtrl_t ctrl,
  output logic    wrPermit,
  output logic    dummyStart
);

  step_t step, nextStep;
  logic authQ, pendSet, pendClr, pendArmed, loadedQ, dummyQ;
  logic isCmd, armMatch, disMatch, dataByte, denied;

  always_comb begin
    nextStep = step;
    isCmd    = 1'b0;
    armMatch = 1'b0;
    disMatch = 1'b0;
    if (wrStb && !authQ) begin
      unique case (step)
        ST_IDLE: if (hits.lead) begin isCmd = 1'b1; nextStep = ST_GOT1; end
        ST_GOT1: if (hits.second) begin isCmd = 1'b1; nextStep = ST_GOT2; end
        ST_GOT2: begin
          if (hits.arm) begin
            isCmd = 1'b1; armMatch = 1'b1; nextStep = ST_IDLE;
          end else if (hits.extend) begin
            isCmd = 1'b1; nextStep = ST_DIS3;
          end
        end
        ST_DIS3: if (hits.lead) begin isCmd = 1'b1; nextStep = ST_DIS4; end
        ST_DIS4: if (hits.second) begin isCmd = 1'b1; nextStep = ST_DIS5; end
        ST_DIS5: begin
          if (hits.disarm) begin
            isCmd = 1'b1; disMatch = 1'b1; nextStep = ST_IDLE;
          end
        end
        default: nextStep = ST_IDLE;
      endcase
      if (!isCmd) begin
        if (hits.lead) begin
          isCmd = 1'b1;
          nextStep = ST_GOT1;
        end else begin
          nextStep = ST_IDLE;
        end
      end
    end
  end

  assign dataByte   = wrStb && !isCmd;
  assign wrPermit   = dataByte && (authQ || !protectOn);
  assign denied     = dataByte && !wrPermit;
  assign dummyStart = (denied && !dummyQ) ||
                      (winExpire && (pendSet || pendClr) && !pendArmed && !loadedQ);

  assign ctrl.openWin = wrStb;
  assign ctrl.setProt = cycleDone && pendArmed && pendSet;
  assign ctrl.clrProt = cycleDone && pendArmed && pendClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step      <= ST_IDLE;
      authQ     <= 1'b0;
      pendSet   <= 1'b0;
      pendClr   <= 1'b0;
      pendArmed <= 1'b0;
      loadedQ   <= 1'b0;
      dummyQ    <= 1'b0;
    end else begin
      if (winExpire) begin
        step    <= ST_IDLE;
        authQ   <= 1'b0;
        loadedQ <= 1'b0;
        dummyQ  <= 1'b0;
        if (pendSet || pendClr) pendArmed <= 1'b1;
      end else if (wrStb) begin
        step <= nextStep;
        if (armMatch) begin
          authQ <= 1'b1; pendSet <= 1'b1; pendClr <= 1'b0; pendArmed <= 1'b0;
        end
        if (disMatch) begin
          authQ <= 1'b1; pendClr <= 1'b1; pendSet <= 1'b0; pendArmed <= 1'b0;
        end
        if (wrPermit) loadedQ <= 1'b1;
        if (denied) dummyQ <= 1'b1;
      end
      if (cycleDone && pendArmed) begin
        pendSet   <= 1'b0;
        pendClr   <= 1'b0;
        pendArmed <= 1'b0;
      end
    end
  end

  AST_PERMIT_HAS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    wrPermit |-> wrStb) else $error("permit without strobe"); // R2

  AST_CMD_NEVER_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && hits.lead && !authQ) |-> !wrPermit) else $error("command byte stored"); // R3

  AST_PROTECT_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (protectOn != $past(protectOn)) |-> $past(cycleDone)) else $error("protect moved"); // R5

  AST_DUMMY_WHEN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (dummyStart && wrStb) |-> protectOn) else $error("dummy while open"); // R6

  AST_ONE_DUMMY: assert property (@(posedge clk) disable iff (!rstN)
    (dummyQ && !winExpire) |-> !dummyStart) else $error("second dummy"); // R6

endmodule

// File: rtl/wp_unlock_guard.sv
module wp_unlock_guard
  import wp_guard_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int LOAD_WINDOW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cycleDone,
  output logic              wrPermit,
  output logic              protectOn,
  output logic              dummyStart
);

  dpCtrl_t ctrl;
  patHit_t hits;
  logic winExpire;

  wp_guard_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LOAD_WINDOW(LOAD_WINDOW)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .ctrl(ctrl),
    .hits(hits),
    .winExpire(winExpire),
    .protectOn(protectOn)
  );

  wp_guard_control u_ctl (
    .clk(clk),
    .rstN(rstN),
    .wrStb(wrStb),
    .hits(hits),
    .winExpire(winExpire),
    .protectOn(protectOn),
    .cycleDone(cycleDone),
    .ctrl(ctrl),
    .wrPermit(wrPermit),
    .dummyStart(dummyStart)
  );

endmodule

// File: tb/wp_unlock_guard_test.sv
module wp_unlock_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int WIN = 8;
  localparam int NV = 39;

  typedef struct packed {
    logic        stb;
    logic [14:0] addr;
    logic [7:0]  data;
    logic        done;
    logic [4:0]  gap;
    logic        ePermit;
    logic        eDummy;
    logic        eProt;
    logic [3:0]  req;
  } vec_t;

  // R2 R3 R4 R6 R7 R8 R9 R10 R11 R12 exercised by the table below
  localparam vec_t VECS [NV] = '{
    '{1'b1, 15'h0100, 8'h11, 1'b0, 5'd1,  1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 15'h2AAA, 8'h55, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b1, 15'h5555, 8'hA0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b1, 15'h0200, 8'h33, 1'b0, 5'd12, 1'b1, 1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 15'h0000, 8'h00, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 4'd4},  // R4
    '{1'b0, 15'h0000, 8'h00, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd4},
    '{1'b1, 15'h0300, 8'h44, 1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd6},  // R6
    '{1'b1, 15'h0301, 8'h45, 1'b0, 5'd12, 1'b0, 1'b0, 1'b1, 4'd6},
    '{1'b0, 15'h0000, 8'h00, 1'b1, 5'd0,  1'b0, 1'b0, 1'b1, 4'd12}, // R12
    '{1'b0, 15'h0000, 8'h00, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd12},
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd3},
    '{1'b1, 15'h2AAA, 8'h55, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd3},
    '{1'b1, 15'h5555, 8'hA0, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd3},
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b1, 1'b0, 1'b1, 4'd7},
    '{1'b1, 15'h0400, 8'h77, 1'b0, 5'd12, 1'b1, 1'b0, 1'b1, 4'd7},
    '{1'b0, 15'h0000, 8'h00, 1'b1, 5'd0,  1'b0, 1'b0, 1'b1, 4'd12},
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd10}, // R10
    '{1'b1, 15'h2AAA, 8'h55, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd10},
    '{1'b1, 15'h0010, 8'h12, 1'b0, 5'd12, 1'b0, 1'b1, 1'b1, 4'd10},
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{1'b1, 15'h2AAA, 8'h55, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd9},
    '{1'b1, 15'h5555, 8'h80, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd9},
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd9},
    '{1'b1, 15'h2AAA, 8'h55, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd9},
    '{1'b1, 15'h5555, 8'h20, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd9},
    '{1'b1, 15'h0500, 8'h99, 1'b0, 5'd12, 1'b1, 1'b0, 1'b1, 4'd9},
    '{1'b0, 15'h0000, 8'h00, 1'b1, 5'd0,  1'b0, 1'b0, 1'b1, 4'd9},
    '{1'b0, 15'h0000, 8'h00, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd9},
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd10},
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd10},
    '{1'b1, 15'h2AAA, 8'h55, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 4'd10},
    '{1'b1, 15'h5555, 8'hA0, 1'b0, 5'd12, 1'b0, 1'b0, 1'b0, 4'd11}, // R11
    '{1'b0, 15'h0000, 8'h00, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 4'd11},
    '{1'b0, 15'h0000, 8'h00, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd11},
    '{1'b1, 15'h5555, 8'hAA, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 4'd8},  // R8
    '{1'b1, 15'h2AAA, 8'h55, 1'b0, 5'd12, 1'b0, 1'b0, 1'b1, 4'd8},
    '{1'b1, 15'h5555, 8'hA0, 1'b0, 5'd0,  1'b0, 1'b1, 1'b1, 4'd8},
    '{1'b1, 15'h0600, 8'h66, 1'b0, 5'd12, 1'b0, 1'b0, 1'b1, 4'd8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic cycleDone = 1'b0;
  logic wrPermit, protectOn, dummyStart;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wp_unlock_guard #(.LOAD_WINDOW(WIN)) uut (
    .clk(clk),
    .rstN(rstN),
    .wrStb(wrStb),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .cycleDone(cycleDone),
    .wrPermit(wrPermit),
    .protectOn(protectOn),
    .dummyStart(dummyStart)
  );

  task automatic check(input logic act, input logic exp, input int req, input string what);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic stb, input logic [14:0] a, input logic [7:0] d,
                       input logic done);
    @(negedge clk);
    wrStb = stb; wrAddr = a; wrData = d; cycleDone = done;
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      apply(1'b0, '0, '0, 1'b0);
      @(posedge clk);
    end
  endtask

  task automatic strobe(input logic [14:0] a, input logic [7:0] d);
    apply(1'b1, a, d, 1'b0);
    @(posedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int pulses;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: state after power-on reset
    apply(1'b0, '0, '0, 1'b0);
    check(protectOn, 1'b0, 1, "protect after reset");
    check(wrPermit, 1'b0, 1, "permit after reset");
    check(dummyStart, 1'b0, 1, "dummy after reset");
    @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].stb, VECS[i].addr, VECS[i].data, VECS[i].done);
      check(wrPermit, VECS[i].ePermit, int'(VECS[i].req), $sformatf("vec %0d permit", i));
      check(dummyStart, VECS[i].eDummy, int'(VECS[i].req), $sformatf("vec %0d dummy", i));
      check(protectOn, VECS[i].eProt, int'(VECS[i].req), $sformatf("vec %0d protect", i));
      @(posedge clk);
      idle(int'(VECS[i].gap));
    end

    // R11: arm pattern with no data while protected -> one dummy pulse at window close
    strobe(15'h5555, 8'hAA);
    strobe(15'h2AAA, 8'h55);
    strobe(15'h5555, 8'hA0);
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      apply(1'b0, '0, '0, 1'b0);
      if (dummyStart) pulses++;
      @(posedge clk);
    end
    check(pulses == 1, 1'b1, 11, "single dummy at window close");
    apply(1'b0, '0, '0, 1'b1);
    @(posedge clk);
    apply(1'b0, '0, '0, 1'b0);
    check(protectOn, 1'b1, 12, "protect kept after re-arm");
    @(posedge clk);

    // R5: early cycleDone inside the window does not commit a disarm
    strobe(15'h5555, 8'hAA);
    strobe(15'h2AAA, 8'h55);
    strobe(15'h5555, 8'h80);
    strobe(15'h5555, 8'hAA);
    strobe(15'h2AAA, 8'h55);
    strobe(15'h5555, 8'h20);
    apply(1'b0, '0, '0, 1'b1);
    @(posedge clk);
    apply(1'b0, '0, '0, 1'b0);
    check(protectOn, 1'b1, 5, "early done ignored");
    @(posedge clk);
    idle(12);
    apply(1'b0, '0, '0, 1'b1);
    @(posedge clk);
    apply(1'b0, '0, '0, 1'b0);
    check(protectOn, 1'b0, 5, "done after close commits");
    @(posedge clk);

    // R1: reset clears an armed flag
    strobe(15'h5555, 8'hAA);
    strobe(15'h2AAA, 8'h55);
    strobe(15'h5555, 8'hA0);
    idle(12);
    apply(1'b0, '0, '0, 1'b1);
    @(posedge clk);
    apply(1'b0, '0, '0, 1'b0);
    check(protectOn, 1'b1, 4, "armed before reset");
    rstN = 1'b0;
    #1;
    check(protectOn, 1'b0, 1, "reset clears protect");
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    strobe(15'h0700, 8'h5A);
    apply(1'b1, 15'h0701, 8'h5B, 1'b0);
    check(wrPermit, 1'b1, 1, "write open after reset");
    @(posedge clk);
    idle(2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule